// File: doc/BRIEF.md
# Segmented Logical-to-Linear Address Translator

This block turns a segment selector and an offset into a linear address. It works in one of two modes, chosen by a mode input sampled with the start strobe. In real mode the 16-bit segment value is scaled by sixteen and added to a 16-bit offset. The 20-bit result is available in the same cycle as the start strobe.

In protected mode the selector picks an entry in either a global or a local descriptor table. The block reads that entry over a simple memory read port, as two 32-bit words in consecutive cycles. It then adds the descriptor base to the full 32-bit offset. If the offset is larger than the descriptor limit, the block raises a fault instead of producing an address. Only one protected-mode translation can be in flight at a time, and start strobes that arrive while the block is busy are dropped.

Top module: `seg_xlat_top`

## Requirements
- R1: Real mode (prot_mode_i=0): lin_addr_o = ({selector_i,4'h0} + offset_i[15:0]) modulo 2^20, with bits [31:20] zero. done_o is high in the same cycle as start_i, and fault_o stays low.
- R2: In real mode, offset_i[31:16] has no effect on the result.
- R3: In protected mode, selector bits [15:3] are the table index and bit 2 chooses the table (1 = local base ltab_base_i, 0 = global base gtab_base_i). Bits [1:0] have no effect.
- R4: The descriptor address is the table base + index*8. rd_req_o is high for exactly two consecutive cycles, first with that address and then with that address + 4. rd_data_i carries the word for a request in the cycle after that request.
- R5: The word at the descriptor address is the 32-bit segment base. In the word at address + 4, bits [19:0] are the byte limit and bits [31:20] are access bits that have no effect.
- R6: In protected mode, lin_addr_o = (base + offset_i) modulo 2^32.
- R7: When offset_i > limit, fault_o is high together with done_o, and lin_addr_o is zero.
- R8: A protected-mode done_o pulse lasts one cycle. It appears in the cycle that follows the third rising edge after the edge that samples start_i.
- R9: A start_i that arrives while a protected translation is in progress, or in its done cycle, is ignored in both modes.
- R10: After reset, done_o, fault_o and rd_req_o are low and lin_addr_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a translation |
| prot_mode_i | input | 1 | 1 = protected mode, 0 = real mode |
| selector_i | input | 16 | Segment value or selector |
| offset_i | input | 32 | Offset within the segment |
| gtab_base_i | input | 32 | Global descriptor table base |
| ltab_base_i | input | 32 | Local descriptor table base |
| rd_req_o | output | 1 | Memory read request |
| rd_addr_o | output | 32 | Memory read address |
| rd_data_i | input | 32 | Read data, one cycle after the request |
| lin_addr_o | output | 32 | Linear address |
| done_o | output | 1 | Translation complete |
| fault_o | output | 1 | Limit violation, valid with done_o |

## Verification
The bench wraps a real-mode sum past 1 MB, where a design that keeps the carry would show bit 20 set. It also sets high offset bits in real mode, which a design that uses the full offset would add in. In protected mode it probes the offset at the limit and one above it, where an off-by-one compare would flip the fault. It sums a base and offset that overflow 32 bits, and it uses selectors that differ only in the table bit or in the two low bits, so a wrong table choice or a decode of the low bits reads the wrong descriptor. A second start issued during a fetch would, in a design that accepts it, produce an extra done pulse, extra reads or a corrupted result.

// File: rtl/seg_xlat_pkg.sv
// Package: shared widths and the fetch sequencer state encoding.
// Assumes selectors are 16 bits with a 13-bit table index.
package seg_xlat_pkg;
    localparam int SEL_W   = 16;
    localparam int IDX_LSB = 3;
    localparam int TBL_BIT = 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_REQ_LO = 2'd1,
        ST_REQ_HI = 2'd2,
        ST_TAKE   = 2'd3
    } fetch_st_t;
endpackage

// File: rtl/seg_real_calc.sv
// Real-mode address: segment scaled by 16 plus a 16-bit offset.
// The sum wraps at REAL_W bits. Purely combinational.
module seg_real_calc #(
    parameter int SEL_W  = 16,
    parameter int REAL_W = 20
) (
    input  logic [SEL_W-1:0]  seg_i,
    input  logic [SEL_W-1:0]  off_i,
    output logic [REAL_W-1:0] lin_o
);
    localparam int SHIFT = REAL_W - SEL_W;

    // Scale the segment, zero-extend the offset, and add.
    always_comb begin
        lin_o = {seg_i, {SHIFT{1'b0}}} + {{SHIFT{1'b0}}, off_i};
    end
endmodule

// File: rtl/seg_desc_fetch.sv
// Descriptor fetch sequencer. On go it latches the descriptor address and
// issues two back-to-back reads. It assumes read data arrives in the cycle
// after each request. desc_vld_o marks the cycle when the limit word is on
// rd_data_i and the base is held in desc_base_o.
module seg_desc_fetch
    import seg_xlat_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int LIMIT_W = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go_i,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic [ADDR_W-1:0]  gtab_i,
    input  logic [ADDR_W-1:0]  ltab_i,
    output logic               busy_o,
    output logic               rd_req_o,
    output logic [ADDR_W-1:0]  rd_addr_o,
    input  logic [ADDR_W-1:0]  rd_data_i,
    output logic               desc_vld_o,
    output logic [ADDR_W-1:0]  desc_base_o,
    output logic [LIMIT_W-1:0] desc_limit_o
);
    localparam int IDX_W = SEL_W - IDX_LSB;
    localparam int PAD_W = ADDR_W - SEL_W;

    fetch_st_t         st_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] ent_addr;
    logic [IDX_W-1:0]  idx;
    logic              unused_sel_low;
    logic              unused_access;

    // Pick the table from the selector and form the entry address.
    always_comb begin
        idx      = sel_i[SEL_W-1:IDX_LSB];
        ent_addr = (sel_i[TBL_BIT] ? ltab_i : gtab_i)
                 + {{PAD_W{1'b0}}, idx, 3'b000};
    end

    assign unused_sel_low = ^sel_i[1:0];
    assign unused_access  = ^rd_data_i[ADDR_W-1:LIMIT_W];

    // Step through the two reads and capture the base word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            addr_q <= '0;
            base_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (go_i) begin
                    addr_q <= ent_addr;
                    st_q   <= ST_REQ_LO;
                end
                ST_REQ_LO: begin
                    addr_q <= addr_q + ADDR_W'(4);
                    st_q   <= ST_REQ_HI;
                end
                ST_REQ_HI: begin
                    base_q <= rd_data_i;
                    st_q   <= ST_TAKE;
                end
                ST_TAKE: st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o       = (st_q != ST_IDLE);
    assign rd_req_o     = (st_q == ST_REQ_LO) || (st_q == ST_REQ_HI);
    assign rd_addr_o    = addr_q;
    assign desc_vld_o   = (st_q == ST_TAKE);
    assign desc_base_o  = base_q;
    assign desc_limit_o = rd_data_i[LIMIT_W-1:0];

    // R4: the second read goes to the word after the first.
    a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && $past(rd_req_o)) |-> (rd_addr_o == $past(rd_addr_o) + ADDR_W'(4)));
    // R4: a read burst is always two cycles long.
    a_r4_two_reads: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_req_o) |=> rd_req_o);
    // R4: no third consecutive read.
    a_r4_no_third: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && $past(rd_req_o)) |=> !rd_req_o);
endmodule

// File: rtl/seg_result_reg.sv
// Protected-mode result stage. It latches the offset at go. When the
// descriptor is valid, it compares the offset with the limit and registers
// either base+offset or a fault, together with a one-cycle done.
module seg_result_reg #(
    parameter int ADDR_W  = 32,
    parameter int LIMIT_W = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [ADDR_W-1:0]  off_i,
    input  logic               desc_vld_i,
    input  logic [ADDR_W-1:0]  desc_base_i,
    input  logic [LIMIT_W-1:0] desc_limit_i,
    output logic               done_o,
    output logic               fault_o,
    output logic [ADDR_W-1:0]  lin_o
);
    logic [ADDR_W-1:0] off_q;
    logic              over;

    // Compare the latched offset with the zero-extended limit.
    always_comb begin
        over = off_q > {{(ADDR_W-LIMIT_W){1'b0}}, desc_limit_i};
    end

    // Hold the offset for the whole fetch.
    always_ff @(posedge clk) begin
        if (!rst_n)      off_q <= '0;
        else if (load_i) off_q <= off_i;
    end

    // Register the outcome once the descriptor is in hand.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o  <= 1'b0;
            fault_o <= 1'b0;
            lin_o   <= '0;
        end else begin
            done_o  <= desc_vld_i;
            fault_o <= desc_vld_i && over;
            if (desc_vld_i) lin_o <= over ? '0 : desc_base_i + off_q;
        end
    end

    // R8: done lasts a single cycle.
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R7: a fault is only reported with done.
    a_r7_fault_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> done_o);
endmodule

// File: rtl/seg_xlat_top.sv
// Logical-to-linear translator top. Real mode answers combinationally in
// the start cycle. Protected mode runs the descriptor fetch and the result
// stage. Starts are taken only when no fetch or done cycle is pending.
module seg_xlat_top #(
    parameter int ADDR_W  = 32,
    parameter int REAL_W  = 20,
    parameter int LIMIT_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              prot_mode_i,
    input  logic [15:0]       selector_i,
    input  logic [ADDR_W-1:0] offset_i,
    input  logic [ADDR_W-1:0] gtab_base_i,
    input  logic [ADDR_W-1:0] ltab_base_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [ADDR_W-1:0] rd_data_i,
    output logic [ADDR_W-1:0] lin_addr_o,
    output logic              done_o,
    output logic              fault_o
);
    import seg_xlat_pkg::*;

    logic               busy;
    logic               idle;
    logic               go_prot;
    logic               real_done;
    logic [REAL_W-1:0]  real_lin;
    logic               desc_vld;
    logic [ADDR_W-1:0]  desc_base;
    logic [LIMIT_W-1:0] desc_limit;
    logic               p_done;
    logic               p_fault;
    logic [ADDR_W-1:0]  p_lin;

    // Accept a start only when neither fetch nor result is pending.
    always_comb begin
        idle      = !busy && !p_done;
        go_prot   = start_i && prot_mode_i && idle;
        real_done = start_i && !prot_mode_i && idle;
    end

    seg_real_calc #(.SEL_W(SEL_W), .REAL_W(REAL_W)) u_real (
        .seg_i (selector_i),
        .off_i (offset_i[SEL_W-1:0]),
        .lin_o (real_lin)
    );

    seg_desc_fetch #(.ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W)) u_fetch (
        .clk          (clk),
        .rst_n        (rst_n),
        .go_i         (go_prot),
        .sel_i        (selector_i),
        .gtab_i       (gtab_base_i),
        .ltab_i       (ltab_base_i),
        .busy_o       (busy),
        .rd_req_o     (rd_req_o),
        .rd_addr_o    (rd_addr_o),
        .rd_data_i    (rd_data_i),
        .desc_vld_o   (desc_vld),
        .desc_base_o  (desc_base),
        .desc_limit_o (desc_limit)
    );

    seg_result_reg #(.ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W)) u_result (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (go_prot),
        .off_i        (offset_i),
        .desc_vld_i   (desc_vld),
        .desc_base_i  (desc_base),
        .desc_limit_i (desc_limit),
        .done_o       (p_done),
        .fault_o      (p_fault),
        .lin_o        (p_lin)
    );

    // Steer the real-mode sum or the registered protected result.
    always_comb begin
        done_o     = real_done || p_done;
        fault_o    = p_fault;
        lin_addr_o = real_done ? {{(ADDR_W-REAL_W){1'b0}}, real_lin} : p_lin;
    end

    // R7: a faulting translation produces no address.
    a_r7_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (lin_addr_o == '0));
    // R1: real-mode results never exceed 1 MB.
    a_r1_real_range: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !prot_mode_i && done_o && !fault_o && !$past(rd_req_o))
            |-> (lin_addr_o[ADDR_W-1:REAL_W] == '0));
    // R9: no read is issued in the done cycle.
    a_r9_quiet_done: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !real_done) |-> !rd_req_o);
endmodule

// File: tb/seg_xlat_top_bench.sv
`timescale 1ns/1ps
module seg_xlat_top_bench;
    localparam time CLK_P = 20ns;
    localparam logic [31:0] GTB = 32'h0000_0000;
    localparam logic [31:0] LTB = 32'h0000_0200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        prot_mode_i = 1'b0;
    logic [15:0] selector_i = '0;
    logic [31:0] offset_i = '0;
    logic        rd_req_o;
    logic [31:0] rd_addr_o;
    logic [31:0] rd_data_i = '0;
    logic [31:0] lin_addr_o;
    logic        done_o;
    logic        fault_o;
    logic [31:0] mem [256];

    int n_run = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_P/2) clk = ~clk;

    seg_xlat_top u_seg_xlat_top (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .prot_mode_i(prot_mode_i),
        .selector_i(selector_i), .offset_i(offset_i),
        .gtab_base_i(GTB), .ltab_base_i(LTB),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
        .lin_addr_o(lin_addr_o), .done_o(done_o), .fault_o(fault_o)
    );

    // Memory model: one cycle of read latency.
    always @(posedge clk) if (rd_req_o) rd_data_i <= mem[rd_addr_o[9:2]];

    // Vector: mode, selector, offset, expected address, expected fault.
    localparam int NV = 12;
    localparam logic [81:0] VEC [NV] = '{
        {1'b0, 16'h08F1, 32'h0000_0100, 32'h0000_9010, 1'b0}, // R1
        {1'b0, 16'h028F, 32'h0000_0030, 32'h0000_2920, 1'b0}, // R1
        {1'b0, 16'hFFFF, 32'h0000_FFFF, 32'h0000_FFEF, 1'b0}, // R1 wrap
        {1'b0, 16'h1000, 32'hABCD_0010, 32'h0001_0010, 1'b0}, // R2
        {1'b1, 16'h0008, 32'h0000_0123, 32'h0010_0123, 1'b0}, // R6 R5
        {1'b1, 16'h000B, 32'h0000_0123, 32'h0010_0123, 1'b0}, // R3 low bits
        {1'b1, 16'h0008, 32'h0000_1000, 32'h0000_0000, 1'b1}, // R7 above
        {1'b1, 16'h0008, 32'h0000_0FFF, 32'h0010_0FFF, 1'b0}, // R7 at limit
        {1'b1, 16'h0010, 32'h0000_2000, 32'h0000_1000, 1'b0}, // R6 wrap
        {1'b1, 16'h001C, 32'h0000_01FF, 32'h0002_61FF, 1'b0}, // R3 local
        {1'b1, 16'h001C, 32'h0000_0200, 32'h0000_0000, 1'b1}, // R7 local
        {1'b1, 16'h0018, 32'h0000_0010, 32'h0050_0010, 1'b0}  // R3 global
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_vec(input logic m, input logic [15:0] s, input logic [31:0] o,
                           input logic [31:0] e, input logic f, input string tag);
        int k = 0;
        int nrd = 0;
        logic [31:0] a0 = '0;
        logic [31:0] a1 = '0;
        logic [31:0] dexp;
        @(negedge clk);
        prot_mode_i = m; selector_i = s; offset_i = o; start_i = 1'b1;
        if (!m) begin
            #1;
            chk(done_o === 1'b1, tag, "real done", {31'b0, done_o}, 32'd1);
            chk(lin_addr_o === e, tag, "real addr", lin_addr_o, e);
            chk(fault_o === 1'b0 && rd_req_o === 1'b0, tag, "real fault/read",
                {30'b0, fault_o, rd_req_o}, 32'd0);
            @(negedge clk);
            start_i = 1'b0;
        end else begin
            dexp = (s[2] ? LTB : GTB) + {16'h0, s[15:3], 3'b000};
            while (done_o !== 1'b1 && k < 10) begin
                @(negedge clk);
                start_i = 1'b0;
                k++;
                if (rd_req_o) begin
                    if (nrd == 0) a0 = rd_addr_o; else a1 = rd_addr_o;
                    nrd++;
                end
            end
            chk(k == 4, {tag, " R8"}, "done latency", k, 32'd4);
            chk(nrd == 2, {tag, " R4"}, "read count", nrd, 32'd2);
            chk(a0 == dexp && a1 == dexp + 4, {tag, " R4"}, "desc addr", a0, dexp);
            chk(fault_o === f, tag, "fault", {31'b0, fault_o}, {31'b0, f});
            chk(lin_addr_o === e, tag, "prot addr", lin_addr_o, e);
            @(negedge clk);
            chk(done_o === 1'b0, {tag, " R8"}, "done pulse width", {31'b0, done_o}, 32'd0);
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        mem[2]   = 32'h0010_0000; mem[3]   = 32'h9A00_0FFF; // global 1, access bits set (R5)
        mem[4]   = 32'hFFFF_F000; mem[5]   = 32'h000F_FFFF; // global 2
        mem[6]   = 32'h0050_0000; mem[7]   = 32'h000F_FFFF; // global 3
        mem[134] = 32'h0002_6000; mem[135] = 32'hF000_01FF; // local 3
    end

    // Watchdog: an overlong run is a failure.
    initial begin
        #(CLK_P * 100000);
        if (!finished) begin
            n_run++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end

    initial begin
        int drops;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: idle state after reset.
        chk(done_o === 0 && fault_o === 0 && rd_req_o === 0, "R10", "ctl after reset",
            {29'b0, done_o, fault_o, rd_req_o}, 32'd0);
        chk(lin_addr_o === 32'h0, "R10", "addr after reset", lin_addr_o, 32'h0);

        for (int v = 0; v < NV; v++)
            run_vec(VEC[v][81], VEC[v][80:65], VEC[v][64:33], VEC[v][32:1], VEC[v][0],
                    $sformatf("vec%0d", v));

        // R9: starts during a fetch are dropped.
        @(negedge clk);
        prot_mode_i = 1'b1; selector_i = 16'h0008; offset_i = 32'h0000_0040; start_i = 1'b1;
        @(negedge clk);
        prot_mode_i = 1'b0; selector_i = 16'h1234; offset_i = 32'h0000_0001;
        #1;
        chk(done_o === 1'b0, "R9", "real start while busy", {31'b0, done_o}, 32'd0);
        @(negedge clk);
        prot_mode_i = 1'b1; selector_i = 16'h0010; offset_i = 32'h0;
        @(negedge clk);
        @(negedge clk);
        // Done cycle of the first request: the held start must not add a real result.
        chk(done_o === 1'b1 && lin_addr_o === 32'h0010_0040, "R9", "first result kept",
            lin_addr_o, 32'h0010_0040);
        start_i = 1'b0;
        drops = 0;
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            if (done_o || rd_req_o) drops++;
        end
        chk(drops == 0, "R9", "no extra activity", drops, 32'd0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule